// File: doc/BRIEF.md
# Graphics Memory Window Address Mapper

This block sits between the CPU and the DRAM controller and turns CPU accesses aimed at the graphics apertures into physical DRAM addresses. It runs in one of four modes. Two of them use a fixed 16-Kbyte frame window in CPU space:
- the compatible mode maps that window straight onto a 16-Kbyte-aligned frame buffer;
- the banked mode uses a two-bit bank register to swap it across up to 64 Kbytes of frame buffer.

The direct mode uses a relocatable 128-Kbyte CPU aperture with no banking. The fourth mode turns the frame windows off.

A separate 16-Kbyte font window maps onto a relocatable font area in DRAM, and that area can be write-protected. The font window has priority over every frame window.

Translation is combinational, from the request port to the output port, using configuration held in registers. A configuration write made in one cycle governs an access presented in the next cycle.

Requests flow through a valid/ready stream with no storage:
- `out_valid` follows `req_valid`, and `req_ready` follows `out_ready`, so the downstream controller applies back-pressure directly to the CPU.
- A blocked font write is the one exception. It is consumed at once (`req_ready` high) without producing an output transfer, and `write_blocked` is raised for that cycle.
- A request must hold its address and direction stable while `req_valid` is high and `req_ready` is low.

Top module: `gfx_win_mapper`

## Requirements
- R1: After reset the mode is compatible, the bank is 0, the frame and font bases are 0, write protect is off and the aperture base is 0x0E0000. With no request, `out_valid` and `write_blocked` are low.
- R2: In compatible mode (`cfg_sel`=0 value 0), an access in the frame window 0xB8000–0xBBFFF maps to the 16-Kbyte-aligned frame base plus address bits [13:0], and the bank register is ignored.
- R3: In banked mode (value 1), a frame window access maps to the 32-Kbyte-aligned frame base + bank×0x4000 + address bits [13:0].
- R4: In direct mode (value 2), an access inside the 128-Kbyte aperture that starts at the aperture base maps to the 32-Kbyte-aligned frame base plus address bits [16:0], and the fixed frame window is not used.
- R5: An access in the font window 0xA0000–0xA3FFF maps to the 16-Kbyte-aligned font base plus address bits [13:0]. This holds in every mode and takes priority over any frame window.
- R6: With write protect set (`cfg_sel`=4, bit 0), a write in the font window raises `write_blocked` for that cycle with `out_valid` low and `req_ready` high. Reads of the font window still map.
- R7: An access that falls in no active window gives `out_hit` low and `out_addr` equal to `req_addr`.
- R8: Base writes drop the bits below the alignment: bits [13:0] for the frame base (`cfg_sel`=2) and font base (3), bits [16:0] for the aperture (5), and bit 14 of the frame base as well in banked and direct modes.
- R9: `out_valid` is `req_valid` and `req_ready` is `out_ready` except for a blocked write. `out_write` follows `req_write`.
- R10: A bank (`cfg_sel`=1, bits [1:0]), base or mode write takes effect for an access in the next cycle.
- R11: In the off mode (value 3), frame accesses miss while the font window still maps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 mode, 1 bank, 2 frame base, 3 font base, 4 protect, 5 aperture |
| cfg_wdata | input | 24 | Configuration write data |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | CPU request accepted |
| req_addr | input | 24 | CPU address |
| req_write | input | 1 | 1 = write, 0 = read |
| out_valid | output | 1 | Translated access valid to DRAM |
| out_ready | input | 1 | DRAM controller ready |
| out_addr | output | 24 | Physical DRAM address |
| out_write | output | 1 | Write strobe to DRAM |
| out_hit | output | 1 | Access fell in an active window |
| write_blocked | output | 1 | Font write suppressed this cycle |

## Verification
The hardest case is an overlap between the font window and a relocated direct aperture. It arises only after the aperture base has been moved onto a 128-Kbyte boundary that covers the font window.

The stimulus moves the aperture to 0x0A0000 and then sends one access inside the font window and one access just beyond it. The first must map as a font access and the second as a frame access.

Protected writes are also issued while `out_ready` is low. This shows that a blocked write is consumed even when the downstream side stalls.

// File: rtl/gwm_pkg.sv
package gwm_pkg;
  typedef enum logic [1:0] {
    MD_COMPAT = 2'd0,
    MD_BANKED = 2'd1,
    MD_DIRECT = 2'd2,
    MD_OFF    = 2'd3
  } gwm_mode_e;

  typedef enum logic [2:0] {
    SEL_MODE  = 3'd0,
    SEL_BANK  = 3'd1,
    SEL_FRAME = 3'd2,
    SEL_FONT  = 3'd3,
    SEL_PROT  = 3'd4,
    SEL_APER  = 3'd5
  } gwm_sel_e;
endpackage

// File: rtl/gwm_cfg.sv
module gwm_cfg #(
  parameter int AW        = 24,
  parameter int WIN_BITS  = 14,
  parameter int BANK_W    = 2,
  parameter int APER_BITS = 17,
  parameter logic [AW-1:0] APER_RST = 24'h0E0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [2:0]              sel_i,
  input  logic [AW-1:0]           wdata_i,
  output gwm_pkg::gwm_mode_e      mode_o,
  output logic [BANK_W-1:0]       bank_o,
  output logic [AW-1:WIN_BITS]    frame_hi_o,
  output logic [AW-1:WIN_BITS]    font_hi_o,
  output logic [AW-1:APER_BITS]   aper_hi_o,
  output logic                    prot_o
);
  import gwm_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o     <= MD_COMPAT;
      bank_o     <= '0;
      frame_hi_o <= '0;
      font_hi_o  <= '0;
      aper_hi_o  <= APER_RST[AW-1:APER_BITS];
      prot_o     <= 1'b0;
    end else if (we_i) begin
      case (gwm_sel_e'(sel_i))
        SEL_MODE:  mode_o     <= gwm_mode_e'(wdata_i[1:0]);
        SEL_BANK:  bank_o     <= wdata_i[BANK_W-1:0];
        SEL_FRAME: frame_hi_o <= wdata_i[AW-1:WIN_BITS];
        SEL_FONT:  font_hi_o  <= wdata_i[AW-1:WIN_BITS];
        SEL_PROT:  prot_o     <= wdata_i[0];
        SEL_APER:  aper_hi_o  <= wdata_i[AW-1:APER_BITS];
        default:   ;
      endcase
    end
  end

  // R10
  bank_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_BANK) |=> bank_o == $past(wdata_i[BANK_W-1:0]));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mode_o));
endmodule

// File: rtl/gwm_xlate.sv
module gwm_xlate #(
  parameter int AW        = 24,
  parameter int WIN_BITS  = 14,
  parameter int BANK_W    = 2,
  parameter int APER_BITS = 17,
  parameter logic [AW-1:0] FB_WIN   = 24'h0B8000,
  parameter logic [AW-1:0] FONT_WIN = 24'h0A0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid_i,
  input  logic [AW-1:0]         addr_i,
  input  gwm_pkg::gwm_mode_e    mode_i,
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [AW-1:WIN_BITS]  frame_hi_i,
  input  logic [AW-1:WIN_BITS]  font_hi_i,
  input  logic [AW-1:APER_BITS] aper_hi_i,
  output logic [AW-1:0]         addr_o,
  output logic                  hit_o,
  output logic                  font_o
);
  import gwm_pkg::*;

  localparam int FLAT_BITS = WIN_BITS + 1;

  logic          fb_in, font_in, ap_in;
  logic [AW-1:0] flat_base, bank_off, win_off, ap_off;

  assign fb_in   = addr_i[AW-1:WIN_BITS] == FB_WIN[AW-1:WIN_BITS];
  assign font_in = addr_i[AW-1:WIN_BITS] == FONT_WIN[AW-1:WIN_BITS];
  assign ap_in   = addr_i[AW-1:APER_BITS] == aper_hi_i;

  assign flat_base = {frame_hi_i[AW-1:FLAT_BITS], {FLAT_BITS{1'b0}}};
  assign bank_off  = {{(AW-BANK_W-WIN_BITS){1'b0}}, bank_i, {WIN_BITS{1'b0}}};
  assign win_off   = {{(AW-WIN_BITS){1'b0}}, addr_i[WIN_BITS-1:0]};
  assign ap_off    = {{(AW-APER_BITS){1'b0}}, addr_i[APER_BITS-1:0]};

  always_comb begin
    addr_o = addr_i;
    hit_o  = 1'b0;
    font_o = 1'b0;
    if (font_in) begin
      font_o = 1'b1;
      hit_o  = 1'b1;
      addr_o = {font_hi_i, addr_i[WIN_BITS-1:0]};
    end else begin
      case (mode_i)
        MD_COMPAT: if (fb_in) begin
          hit_o  = 1'b1;
          addr_o = {frame_hi_i, addr_i[WIN_BITS-1:0]};
        end
        MD_BANKED: if (fb_in) begin
          hit_o  = 1'b1;
          addr_o = flat_base + bank_off + win_off;
        end
        MD_DIRECT: if (ap_in) begin
          hit_o  = 1'b1;
          addr_o = flat_base + ap_off;
        end
        default: ;
      endcase
    end
  end

  // R2
  compat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && hit_o && !font_o && mode_i == MD_COMPAT)
      |-> addr_o[WIN_BITS-1:0] == addr_i[WIN_BITS-1:0]);

  // R3
  banked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && hit_o && !font_o && mode_i == MD_BANKED)
      |-> addr_o[WIN_BITS-1:0] == addr_i[WIN_BITS-1:0]);

  // R11
  off_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == MD_OFF && !font_o) |-> !hit_o);
endmodule

// File: rtl/gfx_win_mapper.sv
module gfx_win_mapper #(
  parameter int AW        = 24,
  parameter int WIN_BITS  = 14,
  parameter int BANK_W    = 2,
  parameter int APER_BITS = 17,
  parameter logic [AW-1:0] FB_WIN   = 24'h0B8000,
  parameter logic [AW-1:0] FONT_WIN = 24'h0A0000,
  parameter logic [AW-1:0] APER_RST = 24'h0E0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_write,
  output logic          out_hit,
  output logic          write_blocked
);
  import gwm_pkg::*;

  gwm_mode_e              mode;
  logic [BANK_W-1:0]      bank;
  logic [AW-1:WIN_BITS]   frame_hi, font_hi;
  logic [AW-1:APER_BITS]  aper_hi;
  logic                   prot, font_acc;

  gwm_cfg #(.AW(AW), .WIN_BITS(WIN_BITS), .BANK_W(BANK_W),
            .APER_BITS(APER_BITS), .APER_RST(APER_RST)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .sel_i(cfg_sel),
    .wdata_i(cfg_wdata), .mode_o(mode), .bank_o(bank),
    .frame_hi_o(frame_hi), .font_hi_o(font_hi),
    .aper_hi_o(aper_hi), .prot_o(prot));

  gwm_xlate #(.AW(AW), .WIN_BITS(WIN_BITS), .BANK_W(BANK_W),
              .APER_BITS(APER_BITS), .FB_WIN(FB_WIN),
              .FONT_WIN(FONT_WIN)) xlate_i (
    .clk(clk), .rst_n(rst_n), .valid_i(req_valid), .addr_i(req_addr),
    .mode_i(mode), .bank_i(bank), .frame_hi_i(frame_hi),
    .font_hi_i(font_hi), .aper_hi_i(aper_hi),
    .addr_o(out_addr), .hit_o(out_hit), .font_o(font_acc));

  assign write_blocked = req_valid && req_write && font_acc && prot;
  assign out_valid     = req_valid && !write_blocked;
  assign req_ready     = out_ready || write_blocked;
  assign out_write     = req_write;

  // R6
  blk_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_blocked |-> (!out_valid && req_ready));

  // R6
  blk_only_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_blocked |-> (req_valid && req_write));

  // R9
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !write_blocked |-> req_ready == out_ready);

  // R7
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> out_addr == req_addr);
endmodule

// File: tb/gfx_win_mapper_tb_top.sv
module gfx_win_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [23:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_addr;
  logic        out_write;
  logic        out_hit;
  logic        write_blocked;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [23:0] addr;
    logic        hit;
    logic        wr;
    string       req;
  } exp_t;
  exp_t q[$];

  // bench's own copy of configuration, as written
  logic [1:0]  m_mode = 2'd0;
  logic [1:0]  m_bank = 2'd0;
  logic [23:0] m_frame = 24'h0;
  logic [23:0] m_font = 24'h0;
  logic        m_prot = 1'b0;
  logic [23:0] m_aper = 24'h0E0000;

  always #5 clk = ~clk;

  gfx_win_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_write(out_write),
    .out_hit(out_hit), .write_blocked(write_blocked));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [24:0] model(input logic [23:0] a);
    logic [23:0] fr16, fr32, ap;
    fr16 = m_frame & 24'hFFC000;
    fr32 = m_frame & 24'hFF8000;
    ap   = m_aper  & 24'hFE0000;
    if (a[23:14] == 10'h028)
      return {1'b1, (m_font & 24'hFFC000) | {10'h0, a[13:0]}};
    case (m_mode)
      2'd0: if (a[23:14] == 10'h02E) return {1'b1, fr16 | {10'h0, a[13:0]}};
      2'd1: if (a[23:14] == 10'h02E)
              return {1'b1, fr32 + {8'h0, m_bank, 14'h0} + {10'h0, a[13:0]}};
      2'd2: if ((a & 24'hFE0000) == ap) return {1'b1, fr32 + {7'h0, a[16:0]}};
      default: ;
    endcase
    return {1'b0, a};
  endfunction

  task automatic cfg(input logic [2:0] sel, input logic [23:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_mode  = d[1:0];
      3'd1: m_bank  = d[1:0];
      3'd2: m_frame = d;
      3'd3: m_font  = d;
      3'd4: m_prot  = d[0];
      3'd5: m_aper  = d;
      default: ;
    endcase
  endtask

  task automatic access(input logic [23:0] a, input logic w, input string req);
    logic [24:0] e;
    exp_t it;
    e = model(a);
    it.addr = e[23:0]; it.hit = e[24]; it.wr = w; it.req = req;
    q.push_back(it);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic blocked_write(input logic [23:0] a);
    req_valid = 1'b1; req_addr = a; req_write = 1'b1;
    @(negedge clk);
    check(write_blocked === 1'b1, "R6", "write_blocked", 24'(write_blocked), 24'h1);
    check(out_valid === 1'b0, "R6", "out_valid", 24'(out_valid), 24'h0);
    check(req_ready === 1'b1, "R6", "req_ready", 24'(req_ready), 24'h1);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && !write_blocked) begin
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected transfer", out_addr, 24'h0);
      end else begin
        exp_t it;
        it = q.pop_front();
        check(out_valid === 1'b1, it.req, "out_valid", 24'(out_valid), 24'h1);
        check(out_addr === it.addr, it.req, "out_addr", out_addr, it.addr);
        check(out_hit === it.hit, it.req, "out_hit", 24'(out_hit), 24'(it.hit));
        check(out_write === it.wr, "R9", "out_write", 24'(out_write), 24'(it.wr));
      end
    end
  end

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=%h expected=%h", 24'h1, 24'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid === 1'b0, "R1", "out_valid idle", 24'(out_valid), 24'h0);
    check(write_blocked === 1'b0, "R1", "write_blocked idle", 24'(write_blocked), 24'h0);
    check(req_ready === 1'b1, "R9", "req_ready idle", 24'(req_ready), 24'h1);
    @(posedge clk); #1;
    access(24'h0B8123, 1'b0, "R1");
    access(24'h0A0010, 1'b0, "R1");
    // R2 + R8: compatible mode, base low bits dropped, bank ignored
    cfg(3'd2, 24'h127FFF);
    access(24'h0B8000, 1'b0, "R10");
    cfg(3'd1, 24'h3);
    access(24'h0BBFFF, 1'b1, "R2");
    access(24'h0B8ABC, 1'b0, "R8");
    // R3: banked
    cfg(3'd0, 24'h1);
    access(24'h0B8ABC, 1'b0, "R3");
    cfg(3'd1, 24'h1);
    access(24'h0B8ABC, 1'b1, "R10");
    cfg(3'd1, 24'h0);
    access(24'h0BBFFF, 1'b0, "R3");
    access(24'h0C0000, 1'b0, "R7");
    // R4: direct
    cfg(3'd0, 24'h2);
    cfg(3'd5, 24'h354321);
    access(24'h35FFFF, 1'b0, "R4");
    access(24'h340000, 1'b1, "R4");
    access(24'h360000, 1'b0, "R7");
    access(24'h0B8000, 1'b0, "R4");
    // R5: font base and priority over aperture
    cfg(3'd3, 24'h7FFFFF);
    access(24'h0A0010, 1'b0, "R5");
    cfg(3'd5, 24'h0A0000);
    access(24'h0A1234, 1'b0, "R5");
    access(24'h0B0000, 1'b0, "R5");
    // R6: protect
    cfg(3'd4, 24'h1);
    blocked_write(24'h0A0020);
    access(24'h0A0020, 1'b0, "R6");
    out_ready = 1'b0;
    blocked_write(24'h0A3FFF);
    // R9: back-pressure on a normal read
    req_valid = 1'b1; req_addr = 24'h0B0000; req_write = 1'b0;
    @(negedge clk);
    check(req_ready === 1'b0, "R9", "req_ready stalled", 24'(req_ready), 24'h0);
    check(out_valid === 1'b1, "R9", "out_valid stalled", 24'(out_valid), 24'h1);
    begin
      logic [24:0] e;
      exp_t it;
      e = model(24'h0B0000);
      it.addr = e[23:0]; it.hit = e[24]; it.wr = 1'b0; it.req = "R9";
      q.push_back(it);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    // R11: off mode
    cfg(3'd0, 24'h3);
    access(24'h0B8000, 1'b0, "R11");
    access(24'h0A0044, 1'b0, "R11");
    cfg(3'd4, 24'h0);
    access(24'h0A0044, 1'b1, "R11");
    @(posedge clk); #1;
    check(q.size() == 0, "R9", "scoreboard drained", 24'(q.size()), 24'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule